// File: doc/BRIEF.md
# Pipelined Word-Memory Bus Slave

This block is an AHB-Lite slave placed in front of an on-chip array of words. A CPU master reaches it through an interconnect that drives the select line. In the address phase the slave registers the address and the direction of the transfer. In the following data phase it either puts the addressed word on the read bus or writes the write-bus word into the array. The address and direction it uses in the data phase are always the registered ones. By then the live address bus already carries the next transfer.

A parameter `WAIT_STATES` sets how many cycles the ready output is held low before each data phase completes. With the default of zero, every access finishes one cycle after its address phase. The next address phase overlaps the current data phase, so loads and stores stream one per cycle. A small controller with three states sequences each transfer:

- `ST_IDLE` means no data phase is in progress.
- `ST_WAIT` means a data phase is stalled while the counter runs.
- `ST_DONE` means the data phase completes in this cycle.

The transitions are:

- `IDLE→DONE` or `DONE→DONE`: a transfer is accepted with no wait states.
- `IDLE→WAIT` or `DONE→WAIT`: a transfer is accepted with wait states.
- `WAIT→WAIT`: the counter has not reached its limit.
- `WAIT→DONE`: the counter reaches `WAIT_STATES-1`.
- `DONE→IDLE` or `IDLE→IDLE`: no transfer is accepted.

Top module: `ahb_sram_slave`

## Requirements
- R1: An address phase is accepted only when `hsel`=1, `hready`=1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). Cycles with IDLE (2'b00), with BUSY (2'b01), or with `hsel`=0 cause no memory access and leave `hreadyout` high in the following cycle.
- R2: With `WAIT_STATES`=0, the addressed word of a load appears on `hrdata` in the cycle after its address phase, and `hreadyout` is high in that cycle.
- R3: For a store, the value on `hwdata` in the data phase (the cycle after the address phase) is written to the word at the registered address.
- R4: The data phase uses only the address and direction registered in the address phase. A change of `haddr`/`hwrite` during the data phase does not alter which word is read or written.
- R5: Accepted transfers stream back-to-back with no idle cycle between them, including a load directly followed by a store and a store followed by a load.
- R6: A load whose address phase immediately follows a store's address phase to the same word returns the newly stored value.
- R7: With `WAIT_STATES`=N>0, `hreadyout` is low for exactly N cycles after each address phase and then high for the completing cycle, in which read data is valid on `hrdata`.
- R8: While `hreadyout` is low, the registered transfer is held unchanged and no new address phase is taken, even if `hsel` and NONSEQ are presented.
- R9: `hresp` is always 0 (OKAY).
- R10: After active-low reset, `hreadyout` is 1 and no transfer is pending. `hrdata` is 0 in every cycle that is not the completing cycle of a load.
- R11: The word index is `haddr[2 +: log2(DEPTH)]`, so the two byte-offset bits and all bits above the index are ignored and addresses alias modulo DEPTH words. Transfers are word-sized (`hsize` ≤ 3'b010).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select from the decoder |
| haddr | input | ADDR_W | Byte address of the address phase |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 = store, 0 = load |
| hsize | input | 3 | Transfer size (word only) |
| hwdata | input | DATA_W | Store data, valid in the data phase |
| hready | input | 1 | Shared bus ready (previous transfer done) |
| hreadyout | output | 1 | Slave ready; low inserts a wait state |
| hrdata | output | DATA_W | Load data |
| hresp | output | 1 | Response, always OKAY |

## Verification
The bench drives every data phase with a fresh random address and direction on the live bus. A slave that read the live `haddr` instead of the registered one would return or corrupt the wrong word. A store followed at once by a load of the same word catches a write that lands after the read, which would return stale data. Unselected, IDLE and BUSY cycles are sent with tempting write data, and the affected word is read back afterwards to catch any spurious write. A second instance with two wait states has a new NONSEQ store presented while it is stalled. A slave that sampled during the stall would complete an extra transfer, show a wrong count of low-ready cycles, or overwrite the word that is read back later.

// File: rtl/ahb_sram_pkg.sv
package ahb_sram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } dp_state_t;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_BUSY   = 2'b01;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ    = 2'b11;

    localparam logic [2:0] SIZE_WORD = 3'b010;
endpackage

// File: rtl/ahb_sram_capture.sv
module ahb_sram_capture #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    output logic              accept,
    output logic              valid_r,
    output logic              write_r,
    output logic [ADDR_W-1:0] addr_r
);
    // NONSEQ and SEQ both have the upper transfer-type bit set
    assign accept = hsel && hready && htrans[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_r <= 1'b0;
            write_r <= 1'b0;
            addr_r  <= '0;
        end else if (hready) begin
            valid_r <= accept;
            if (accept) begin
                write_r <= hwrite;
                addr_r  <= haddr;
            end
        end
    end

    // R8: a stalled bus freezes the registered transfer
    p_hold_in_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |=> ($stable(addr_r) && $stable(write_r) && $stable(valid_r)));
endmodule

// File: rtl/ahb_sram_ctrl.sv
module ahb_sram_ctrl
    import ahb_sram_pkg::*;
#(
    parameter int WAIT_STATES = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic valid_r,
    input  logic write_r,
    output logic hreadyout,
    output logic mem_we,
    output logic rd_en
);
    localparam int CNT_W  = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
    localparam int LAST_I = (WAIT_STATES > 0) ? WAIT_STATES - 1 : 0;

    dp_state_t        state, state_n;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        state_n = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_DONE: begin
                if (accept) state_n = (WAIT_STATES == 0) ? ST_DONE : ST_WAIT;
                else        state_n = ST_IDLE;
            end
            ST_WAIT: begin
                if (cnt == CNT_W'(LAST_I)) state_n = ST_DONE;
                else                       state_n = ST_WAIT;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= (state == ST_WAIT && state_n == ST_WAIT) ? cnt + CNT_W'(1) : '0;
        end
    end

    always_comb begin
        hreadyout = 1'b1;
        mem_we    = 1'b0;
        rd_en     = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: hreadyout = 1'b0;
            ST_DONE: begin
                mem_we = write_r;
                rd_en  = !write_r;
            end
            default: ;
        endcase
    end

    // R3: the array is written only inside a registered transfer
    p_we_in_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> valid_r);
    // R2: zero-wait completion one cycle after acceptance
    p_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (WAIT_STATES == 0 && accept) |=> hreadyout);
    // R7: a wait state follows every accepted address phase
    p_wait_inserted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (WAIT_STATES > 0 && accept) |=> !hreadyout);
    // R10: ready is low only with a transfer pending
    p_stall_needs_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !hreadyout |-> valid_r);
    // R1: nothing accepted, nothing accessed
    p_idle_no_access_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hreadyout && !accept) |=> !(mem_we || rd_en));
endmodule

// File: rtl/ahb_sram_array.sv
module ahb_sram_array #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
    end

    assign rdata = rd_en ? mem[idx] : '0;
endmodule

// File: rtl/ahb_sram_slave.sv
module ahb_sram_slave
    import ahb_sram_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 64,
    parameter int WAIT_STATES = 0
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    output logic              hreadyout,
    output logic [DATA_W-1:0] hrdata,
    output logic              hresp
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              accept, valid_r, write_r, mem_we, rd_en;
    logic [ADDR_W-1:0] addr_r;
    logic [IDX_W-1:0]  word_idx;

    ahb_sram_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk     (hclk),
        .rst_n   (hresetn),
        .hsel    (hsel),
        .hready  (hready),
        .htrans  (htrans),
        .hwrite  (hwrite),
        .haddr   (haddr),
        .accept  (accept),
        .valid_r (valid_r),
        .write_r (write_r),
        .addr_r  (addr_r)
    );

    ahb_sram_ctrl #(.WAIT_STATES(WAIT_STATES)) u_ctrl (
        .clk       (hclk),
        .rst_n     (hresetn),
        .accept    (accept),
        .valid_r   (valid_r),
        .write_r   (write_r),
        .hreadyout (hreadyout),
        .mem_we    (mem_we),
        .rd_en     (rd_en)
    );

    // word index from the registered address, byte offset dropped
    assign word_idx = addr_r[2 +: IDX_W];

    ahb_sram_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk   (hclk),
        .we    (mem_we),
        .rd_en (rd_en),
        .idx   (word_idx),
        .wdata (hwdata),
        .rdata (hrdata)
    );

    assign hresp = 1'b0;

    // R11: only word-sized transfers are served
    p_word_size_r11: assert property (@(posedge hclk) disable iff (!hresetn)
        accept |-> (hsize <= SIZE_WORD));
endmodule

// File: tb/ahb_sram_slave_bench.sv
module ahb_sram_slave_bench;
    import ahb_sram_pkg::*;

    localparam int DEPTH = 64;
    localparam int IW    = 6;

    logic        hclk = 1'b0;
    logic        hresetn;
    logic        hsel, hwrite, hready, hreadyout, hresp;
    logic [31:0] haddr, hwdata, hrdata;
    logic [1:0]  htrans;
    logic        hsel_w, hwrite_w, hready_w, hreadyout_w, hresp_w;
    logic [31:0] haddr_w, hwdata_w, hrdata_w;
    logic [1:0]  htrans_w;

    always #5 hclk = ~hclk;

    assign hready   = hreadyout;
    assign hready_w = hreadyout_w;

    ahb_sram_slave u_ahb_sram_slave (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(SIZE_WORD), .hwdata(hwdata),
        .hready(hready), .hreadyout(hreadyout), .hrdata(hrdata), .hresp(hresp)
    );

    ahb_sram_slave #(.WAIT_STATES(2)) u_ahb_sram_slave_w2 (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel_w), .haddr(haddr_w),
        .htrans(htrans_w), .hwrite(hwrite_w), .hsize(SIZE_WORD), .hwdata(hwdata_w),
        .hready(hready_w), .hreadyout(hreadyout_w), .hrdata(hrdata_w), .hresp(hresp_w)
    );

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [31:0] model [DEPTH];

    // pending data phase of the zero-wait instance
    bit          p_v, p_w;
    logic [IW-1:0] p_idx;
    logic [31:0] p_wd;
    bit          last_w;
    logic [IW-1:0] last_idx;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // called just after a falling edge: check the current data phase, drive the next address phase
    task automatic cycle(input bit sel, input logic [1:0] tr, input bit wr, input logic [31:0] addr);
        check(hresp == 1'b0, "R9", {31'd0, hresp}, 32'd0);
        if (p_v) begin
            check(hreadyout == 1'b1, "R2/R5 ready", {31'd0, hreadyout}, 32'd1);
            if (p_w) begin
                hwdata = p_wd;               // R3 store data in data phase
                model[p_idx] = p_wd;
            end else begin
                hwdata = $urandom;
                if (last_w && last_idx == p_idx)
                    check(hrdata == model[p_idx], "R6 store-then-load", hrdata, model[p_idx]);
                else
                    check(hrdata == model[p_idx], "R2/R4 load", hrdata, model[p_idx]);
            end
        end else begin
            hwdata = $urandom;
            check(hrdata == 32'd0, "R10 quiet rdata", hrdata, 32'd0);
            check(hreadyout == 1'b1, "R1 idle ready", {31'd0, hreadyout}, 32'd1);
        end
        last_w   = p_v && p_w;
        last_idx = p_idx;
        hsel = sel; htrans = tr; hwrite = wr; haddr = addr;
        p_v   = sel && tr[1];
        p_w   = wr;
        p_idx = addr[2 +: IW];
        p_wd  = $urandom;
        @(negedge hclk);
    endtask

    // one transfer on the wait-state instance; a NONSEQ store to 0x3C is offered during the stall
    task automatic wxfer(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                         output logic [31:0] rd, output int lows);
        hsel_w = 1'b1; htrans_w = TR_NONSEQ; hwrite_w = wr; haddr_w = addr;
        @(negedge hclk);
        hwdata_w = wd;
        hwrite_w = 1'b1; haddr_w = 32'h3C;   // R8 bait while stalled
        lows = 0;
        while (!hreadyout_w && lows < 10) begin
            lows++;
            @(negedge hclk);
        end
        rd = hrdata_w;
        hsel_w = 1'b0; htrans_w = TR_IDLE;
        @(negedge hclk);
        check(hreadyout_w == 1'b1, "R8 no extra transfer", {31'd0, hreadyout_w}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge hclk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [31:0] rd;
        int lows;
        void'($urandom(32'd4242));
        hresetn = 1'b0;
        hsel = 0; htrans = TR_IDLE; hwrite = 0; haddr = 0; hwdata = 0;
        hsel_w = 0; htrans_w = TR_IDLE; hwrite_w = 0; haddr_w = 0; hwdata_w = 0;
        p_v = 0; p_w = 0; p_idx = 0; p_wd = 0; last_w = 0; last_idx = 0;
        repeat (3) @(negedge hclk);
        check(hreadyout == 1'b1, "R10 reset ready", {31'd0, hreadyout}, 32'd1);
        check(hreadyout_w == 1'b1, "R10 reset ready w", {31'd0, hreadyout_w}, 32'd1);
        check(hrdata == 32'd0, "R10 reset rdata", hrdata, 32'd0);
        hresetn = 1'b1;
        @(negedge hclk);

        // fill every word back-to-back (R5), alternating NONSEQ and SEQ
        for (int i = 0; i < DEPTH; i++)
            cycle(1'b1, (i % 2 == 0) ? TR_NONSEQ : TR_SEQ, 1'b1, 32'(i * 4));
        // read every word back-to-back, live address moving (R4, R5)
        for (int i = 0; i < DEPTH; i++)
            cycle(1'b1, TR_SEQ, 1'b0, 32'(i * 4));
        // R6 store then load same word, then load then store
        cycle(1'b1, TR_NONSEQ, 1'b1, 32'h20);
        cycle(1'b1, TR_NONSEQ, 1'b0, 32'h20);
        cycle(1'b1, TR_NONSEQ, 1'b1, 32'h24);
        cycle(1'b1, TR_NONSEQ, 1'b0, 32'h24);
        // R11 aliasing and ignored byte offset
        cycle(1'b1, TR_NONSEQ, 1'b1, 32'(5 * 4 + DEPTH * 4 * 3 + 2));
        cycle(1'b1, TR_NONSEQ, 1'b0, 32'(5 * 4));
        // R1 no access for hsel low, IDLE and BUSY
        cycle(1'b0, TR_NONSEQ, 1'b1, 32'h8);
        cycle(1'b1, TR_IDLE,   1'b1, 32'h8);
        cycle(1'b1, TR_BUSY,   1'b1, 32'h8);
        cycle(1'b0, TR_IDLE,   1'b0, 32'h0);
        cycle(1'b1, TR_NONSEQ, 1'b0, 32'h8);
        // constrained random traffic
        for (int i = 0; i < 600; i++)
            cycle(($urandom % 8) != 0, 2'($urandom), 1'($urandom), $urandom);
        cycle(1'b0, TR_IDLE, 1'b0, 32'h0);
        cycle(1'b0, TR_IDLE, 1'b0, 32'h0);

        // wait-state instance: R7, R8
        wxfer(1'b1, 32'h3C, 32'hA5A5_0001, rd, lows);
        check(lows == 2, "R7 wait count", 32'(lows), 32'd2);
        wxfer(1'b1, 32'h10, 32'h1234_5678, rd, lows);
        check(lows == 2, "R7 wait count", 32'(lows), 32'd2);
        wxfer(1'b0, 32'h10, 32'hDEAD_BEEF, rd, lows);
        check(rd == 32'h1234_5678, "R7 read after waits", rd, 32'h1234_5678);
        check(lows == 2, "R7 wait count", 32'(lows), 32'd2);
        wxfer(1'b0, 32'h3C, 32'hDEAD_BEEF, rd, lows);
        check(rd == 32'hA5A5_0001, "R8 stalled store ignored", rd, 32'hA5A5_0001);
        check(hresp_w == 1'b0, "R9 w", {31'd0, hresp_w}, 32'd0);
        finish_up();
    end
endmodule